// File: doc/BRIEF.md
# Peripheral Register Bank with Bitwise Set and Clear Aliases

This block is the software-visible register file of a small peripheral. It sits on a plain synchronous register bus with a word address, a write strobe, write data and a combinational read-data return. It holds three kinds of register. The first is an on/off switch for the peripheral. The second kind is two bit-field registers, an interrupt-enable mask and a configuration word. The third is a group of task registers that start actions inside the peripheral.

Each bit-field register takes three consecutive word addresses: the register itself, then a SET alias, then a CLR alias. Software can raise or drop individual bits through the aliases without first reading the register. A task can be requested in two ways: software writes a 1 to the task's own address, or logic elsewhere on the chip raises that task's trigger input. The request turns into a one-cycle pulse on the task output, but only while the peripheral is switched on.

Top module: `periph_regbank`

## Requirements
- R1: After reset, every register is zero: the on/off switch is off, the interrupt-enable mask and the configuration word are zero, and no task pulse is present.
- R2: The word map is as follows. The on/off switch is at address 0 and uses bit 0. The interrupt-enable mask is at 4, its SET alias at 5 and its CLR alias at 6. The configuration word is at 8, its SET alias at 9 and its CLR alias at 10. Task i is at address 16+i. A write to a main address replaces the whole register. Write bits above a register's width are dropped, and those bits read as zero.
- R3: A write to a SET alias forces to 1 every register bit whose write-data bit is 1. It leaves every other bit unchanged.
- R4: A write to a CLR alias forces to 0 every register bit whose write-data bit is 1. It leaves every other bit unchanged, so writing all ones clears the whole register.
- R5: A read from a SET or CLR alias returns the current value of its main register.
- R6: While the peripheral is on, a write with data bit 0 set to a task address produces a pulse on that task's output bit only. The pulse is high for exactly the one cycle after the write edge. A task write with data bit 0 clear produces no pulse.
- R7: While the peripheral is on, each cycle a trigger input bit is high produces a pulse on the matching task output in the next cycle.
- R8: While the switch is off, task writes and trigger inputs produce no pulse. Gating uses the switch value held before the edge, so a request in the same cycle as a write that turns the peripheral off still fires.
- R9: A bus write and a trigger for the same task in the same cycle produce one single-cycle pulse.
- R10: Task addresses and unmapped addresses read as zero. Writes to unmapped addresses change no register.
- R11: Read data follows the address in the same cycle. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| task_trig | input | N_TASK | Hardware task request, one bit per task |
| irq_en | output | IEN_W | Interrupt-enable mask |
| cfg | output | CFG_W | Configuration word |
| enabled | output | 1 | Peripheral on/off state |
| task_pulse | output | N_TASK | One-cycle task pulses |

## Verification
The bench uses the default parameters: a 32-bit bus, an 8-bit interrupt-enable mask, a full-width configuration word and four tasks. With a mask narrower than the bus, the test can check that upper write bits are dropped and read back as zero. With a full-width configuration word, the test can check that SET and CLR patterns in the top half of the word are handled. Four tasks allow a check that a write to one task address leaves the neighbouring tasks quiet. They also allow trigger patterns that light several outputs at once.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;
  localparam int A_ENABLE = 0;
  localparam int A_IEN    = 4;
  localparam int A_CFG    = 8;
  localparam int A_TASK   = 16;
  localparam int OFS_SET  = 1;
  localparam int OFS_CLR  = 2;

  typedef enum logic [1:0] {SC_NONE, SC_MAIN, SC_SET, SC_CLR} sc_op_e;
endpackage

// File: rtl/setclr_reg.sv
`timescale 1ns/1ps
module setclr_reg
  import scr_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 6,
  parameter int BASE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q,
  output sc_op_e            op
);
  function automatic logic [W-1:0] next_val(input sc_op_e o, input logic [W-1:0] cur,
                                            input logic [W-1:0] d);
    case (o)
      SC_MAIN: return d;
      SC_SET:  return cur | d;
      SC_CLR:  return cur & ~d;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    op = SC_NONE;
    if (bus_we) begin
      if (bus_addr == ADDR_W'(BASE))                 op = SC_MAIN;
      else if (bus_addr == ADDR_W'(BASE + OFS_SET))  op = SC_SET;
      else if (bus_addr == ADDR_W'(BASE + OFS_CLR))  op = SC_CLR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= next_val(op, q, wdata);
  end

  p_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == SC_MAIN |=> q == $past(wdata));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op == SC_NONE |=> $stable(q));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == SC_SET |=> ((q & $past(wdata)) == $past(wdata)) &&
                     ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == SC_CLR |=> ((q & $past(wdata)) == '0) &&
                     ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
endmodule

// File: rtl/task_unit.sv
`timescale 1ns/1ps
module task_unit #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] bus_req,
  input  logic [N-1:0] hw_trig,
  output logic [N-1:0] req,
  output logic [N-1:0] pulse
);
  always_comb req = (bus_req | hw_trig) & {N{en}};

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= req;
  end

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pulse == '0);
  p_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hw_trig != '0) |=> (pulse & $past(hw_trig)) == $past(hw_trig));
  p_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_req != '0) |=> (pulse & $past(bus_req)) == $past(bus_req));
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req == '0 && hw_trig == '0) |=> pulse == '0);
endmodule

// File: rtl/periph_regbank.sv
`timescale 1ns/1ps
module periph_regbank
  import scr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int IEN_W  = 8,
  parameter int CFG_W  = 32,
  parameter int N_TASK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_TASK-1:0] task_trig,
  output logic [IEN_W-1:0]  irq_en,
  output logic [CFG_W-1:0]  cfg,
  output logic              enabled,
  output logic [N_TASK-1:0] task_pulse
);
  localparam int TASK_END = A_TASK + N_TASK;

  sc_op_e              ien_op, cfg_op;
  logic                en_wr;
  logic                ien_sel, cfg_sel, rd_hit;
  logic [N_TASK-1:0]   task_bus_req, task_req;

  always_comb en_wr = bus_we && (bus_addr == ADDR_W'(A_ENABLE));

  always_ff @(posedge clk) begin
    if (!rst_n)     enabled <= 1'b0;
    else if (en_wr) enabled <= bus_wdata[0];
  end

  setclr_reg #(.W(IEN_W), .ADDR_W(ADDR_W), .BASE(A_IEN)) u_ien (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .wdata(bus_wdata[IEN_W-1:0]), .q(irq_en), .op(ien_op));

  setclr_reg #(.W(CFG_W), .ADDR_W(ADDR_W), .BASE(A_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .wdata(bus_wdata[CFG_W-1:0]), .q(cfg), .op(cfg_op));

  for (genvar i = 0; i < N_TASK; i++) begin : g_task_dec
    assign task_bus_req[i] = bus_we && bus_wdata[0] &&
                             (bus_addr == ADDR_W'(A_TASK + i));
  end

  task_unit #(.N(N_TASK)) u_task (
    .clk(clk), .rst_n(rst_n), .en(enabled), .bus_req(task_bus_req),
    .hw_trig(task_trig), .req(task_req), .pulse(task_pulse));

  always_comb begin
    ien_sel = (bus_addr >= ADDR_W'(A_IEN)) && (bus_addr <= ADDR_W'(A_IEN + OFS_CLR));
    cfg_sel = (bus_addr >= ADDR_W'(A_CFG)) && (bus_addr <= ADDR_W'(A_CFG + OFS_CLR));
    rd_hit  = 1'b1;
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_ENABLE)) bus_rdata[0] = enabled;
    else if (ien_sel)                  bus_rdata[IEN_W-1:0] = irq_en;
    else if (cfg_sel)                  bus_rdata[CFG_W-1:0] = cfg;
    else                               rd_hit = 1'b0;
  end

  p_alias_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ien_sel |-> bus_rdata[IEN_W-1:0] == irq_en);
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> bus_rdata == '0);
  p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(enabled));
  p_task_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr < ADDR_W'(A_TASK) || bus_addr >= ADDR_W'(TASK_END))) |-> task_bus_req == '0);
endmodule

// File: tb/tb_periph_regbank.sv
`timescale 1ns/1ps
module tb_periph_regbank;
  localparam int AW = 6, DW = 32, IW = 8, CW = 32, NT = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic bus_we;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [NT-1:0] task_trig, task_pulse;
  logic [IW-1:0] irq_en;
  logic [CW-1:0] cfg;
  logic enabled;

  periph_regbank #(.ADDR_W(AW), .DATA_W(DW), .IEN_W(IW), .CFG_W(CW), .N_TASK(NT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .task_trig(task_trig),
    .irq_en(irq_en), .cfg(cfg), .enabled(enabled), .task_pulse(task_pulse));

  typedef struct {
    string         req;
    logic [NT-1:0] pulse;
    logic [IW-1:0] ien;
    logic [CW-1:0] cfg;
    logic          en;
    bit            chk_rd;
    logic [DW-1:0] rd;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit m_en = 0;
  logic [IW-1:0] m_ien = '0;
  logic [CW-1:0] m_cfg = '0;

  function automatic logic [DW-1:0] model_read(input int a);
    logic [DW-1:0] v = '0;
    if (a == 0) v[0] = m_en;
    else if (a >= 4 && a <= 6) v[IW-1:0] = m_ien;
    else if (a >= 8 && a <= 10) v[CW-1:0] = m_cfg;
    return v;
  endfunction

  task automatic cmp(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input int a, input bit we, input logic [DW-1:0] d,
                    input logic [NT-1:0] trig, input string req, input bit chk_rd = 0);
    exp_t e;
    @(negedge clk);
    bus_addr = AW'(a); bus_we = we; bus_wdata = d; task_trig = trig;
    e.req = req;
    e.chk_rd = chk_rd && !we;
    e.rd = model_read(a);
    e.pulse = '0;
    if (m_en) begin
      e.pulse = trig;
      if (we && d[0] && a >= 16 && a < 16 + NT) e.pulse[a-16] = 1'b1;
    end
    if (we) begin
      case (a)
        0:  m_en = d[0];
        4:  m_ien = d[IW-1:0];
        5:  m_ien = m_ien | d[IW-1:0];
        6:  m_ien = m_ien & ~d[IW-1:0];
        8:  m_cfg = d[CW-1:0];
        9:  m_cfg = m_cfg | d[CW-1:0];
        10: m_cfg = m_cfg & ~d[CW-1:0];
        default: ;
      endcase
    end
    e.ien = m_ien; e.cfg = m_cfg; e.en = m_en;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      cmp(e.req, "task_pulse", DW'(task_pulse), DW'(e.pulse));
      cmp(e.req, "irq_en", DW'(irq_en), DW'(e.ien));
      cmp(e.req, "cfg", DW'(cfg), DW'(e.cfg));
      cmp(e.req, "enabled", DW'(enabled), DW'(e.en));
      if (e.chk_rd) cmp(e.req, "rdata", bus_rdata, e.rd);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; task_trig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cmp("R1", "irq_en", DW'(irq_en), '0);
    cmp("R1", "cfg", DW'(cfg), '0);
    cmp("R1", "enabled", DW'(enabled), '0);
    cmp("R1", "task_pulse", DW'(task_pulse), '0);
    op(0, 0, 0, '0, "R1", 1);
    op(4, 0, 0, '0, "R1", 1);
    // R8: requests while disabled
    op(17, 1, 1, '0, "R8");
    op(0, 0, 0, 4'b1111, "R8");
    // R2 / R3 / R4 / R5 on the narrow mask
    op(4, 1, 32'hFFFF_FFA5, '0, "R2");
    op(4, 0, 0, '0, "R2", 1);
    op(5, 1, 32'h0000_000A, '0, "R3");
    op(5, 0, 0, '0, "R5", 1);
    op(6, 1, 32'h0000_0005, '0, "R4");
    op(6, 0, 0, '0, "R5", 1);
    op(5, 1, 32'h0, '0, "R3");
    op(6, 1, 32'hFFFF_FFFF, '0, "R4");
    op(4, 0, 0, '0, "R4", 1);
    // full-width configuration word
    op(8, 1, 32'h1234_5678, '0, "R2");
    op(9, 1, 32'h8001_0001, '0, "R3");
    op(10, 1, 32'h0204_0008, '0, "R4");
    op(9, 0, 0, '0, "R5", 1);
    op(10, 0, 0, '0, "R5", 1);
    op(8, 0, 0, '0, "R11", 1);
    // R10: unmapped and task reads, unmapped writes
    op(63, 1, 32'hFFFF_FFFF, '0, "R10");
    op(63, 0, 0, '0, "R10", 1);
    op(7, 1, 32'hFFFF_FFFF, '0, "R10");
    op(18, 0, 0, '0, "R10", 1);
    // switch on
    op(0, 1, 1, '0, "R2");
    op(0, 0, 0, '0, "R2", 1);
    // R6: bus task writes
    op(18, 1, 1, '0, "R6");
    op(0, 0, 0, '0, "R6");
    op(18, 1, 0, '0, "R6");
    op(16, 1, 2, '0, "R6");
    op(19, 1, 32'hFFFF_FFFF, '0, "R6");
    op(16, 0, 0, '0, "R10", 1);
    // R7: hardware triggers
    op(0, 0, 0, 4'b1001, "R7");
    op(0, 0, 0, 4'b0110, "R7");
    op(0, 0, 0, 4'b0110, "R7");
    op(0, 0, 0, '0, "R7");
    // R9: same task from both sources
    op(17, 1, 1, 4'b0010, "R9");
    op(0, 0, 0, '0, "R9");
    // R8: switch-off cycle still fires, then silence
    op(0, 1, 0, 4'b0100, "R8");
    op(0, 0, 0, 4'b1111, "R8");
    op(16, 1, 1, '0, "R8");
    op(11, 0, 0, '0, "R10", 1);
    @(negedge clk);
    bus_we = 1'b0; task_trig = '0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule